// File: doc/BRIEF.md
# Serial Port Modem Line Status Register

This block is the modem line status register of a 16550-class serial port. It watches four active-low modem handshake inputs: clear-to-send, data-set-ready, ring and carrier detect. Each pin passes through a two-flop synchroniser. The register shows the asserted state of each line in its upper nibble. Its lower nibble holds four sticky change flags, and a modem-status interrupt request is raised while any of those flags is set. A host read returns the full byte and clears the change flags.

A loopback enable lets the register take its line state from the port's own control outputs instead of the pins. The four control outputs are request-to-send, data-terminal-ready and the two general-purpose outputs. Change detection then follows those looped values, so software can exercise the interrupt path with no modem attached.

Top module: `mstat_reg`

## Requirements
- R1: Outside loopback, rd_data bits 4, 5, 6 and 7 are the complements of the synchronised n_cts, n_dsr, n_ri and n_dcd inputs, in that order.
- R2: With loop_en high, rd_data bits 4, 5, 6 and 7 equal ctl_rts, ctl_dtr, ctl_out1 and ctl_out2, and the four modem pins have no effect on rd_data.
- R3: rd_data bit 0 is set when the clear-to-send line changes in either direction.
- R4: rd_data bit 1 is set when the data-set-ready line changes in either direction.
- R5: rd_data bit 2 is set only when n_ri goes from 0 to 1. An n_ri change from 1 to 0 leaves bit 2 unchanged.
- R6: rd_data bit 3 is set when the carrier-detect line changes in either direction.
- R7: rd_data is valid in the cycle rd_stb is high, and that read clears bits 0 to 3 at the next clock edge. A change detected in the read cycle stays set after the read.
- R8: irq is high exactly when at least one of rd_data bits 0 to 3 is 1.
- R9: After reset, bits 0 to 3 are 0 and bits 4 to 7 reflect the inputs present. Input levels held through reset set no change flag.
- R10: A pin change appears in rd_data three clock edges after it occurs, and not after two.
- R11: In loopback, change flags follow the control values, and pin toggles set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle host read of the register |
| n_cts | input | 1 | Clear-to-send pin, active low, asynchronous |
| n_dsr | input | 1 | Data-set-ready pin, active low, asynchronous |
| n_ri | input | 1 | Ring pin, active low, asynchronous |
| n_dcd | input | 1 | Carrier-detect pin, active low, asynchronous |
| loop_en | input | 1 | Loopback enable from the modem control register |
| ctl_rts | input | 1 | Request-to-send control output value |
| ctl_dtr | input | 1 | Data-terminal-ready control output value |
| ctl_out1 | input | 1 | General-purpose control output 1 value |
| ctl_out2 | input | 1 | General-purpose control output 2 value |
| rd_data | output | 8 | Register contents: status in [7:4], change flags in [3:0] |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A wrong stored line level shows up as a false change flag. The flag reaches rd_data and irq one edge after the next input sample, and it stays there until a read, so any later read exposes it. A read clear that is lost or mistimed shows up on the next read, or at once on irq. A ring flag on the wrong edge, or a swapped loopback route, shows up in the first read after the stimulus that is aimed at it.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
    localparam int unsigned NLINES = 4;
    localparam int unsigned RING_IDX = 2;

    typedef logic [NLINES-1:0] line_t;

    typedef struct packed {
        line_t cur;
        line_t delta;
        logic  irq;
    } mstat_state_t;
endpackage

// File: rtl/mstat_sync.sv
module mstat_sync #(
    parameter int unsigned WIDTH   = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= {WIDTH{RST_VAL}};
        end else begin
            chain_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/mstat_delta.sv
module mstat_delta
    import mstat_pkg::*;
#(
    parameter int unsigned SETTLE_CYC = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rd_stb,
    input  line_t level,
    output line_t cur,
    output line_t delta,
    output logic  irq
);
    localparam int unsigned CW = $clog2(SETTLE_CYC + 1);

    mstat_state_t st_d, st_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          settled;
    line_t         set_v;

    always_comb begin
        settled = (cnt_q == CW'(SETTLE_CYC));
        cnt_d   = settled ? cnt_q : cnt_q + CW'(1);
        set_v   = level ^ st_q.cur;
        set_v[RING_IDX] = st_q.cur[RING_IDX] & ~level[RING_IDX];
        if (!settled) set_v = '0;
        st_d       = st_q;
        st_d.cur   = level;
        st_d.delta = (rd_stb ? '0 : st_q.delta) | set_v;
        st_d.irq   = |st_d.delta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign cur   = st_q.cur;
    assign delta = st_q.delta;
    assign irq   = st_q.irq;

    // R7: flags survive while no read occurs
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((st_q.delta & $past(st_q.delta)) == $past(st_q.delta)));

    // R7: a read with no new change leaves the flags clear
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && level == st_q.cur) |=> (st_q.delta == '0));

    // R5: the ring line becoming asserted sets no flag
    a_r5_ring_lead_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && !st_q.cur[RING_IDX] && level[RING_IDX] && !st_q.delta[RING_IDX])
        |=> !st_q.delta[RING_IDX]);

    // R9: nothing is flagged during the settle window after reset
    a_r9_quiet_settle: assert property (@(posedge clk) disable iff (!rst_n)
        !settled |=> (st_q.delta == '0));
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
    import mstat_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_stb,
    input  logic       n_cts,
    input  logic       n_dsr,
    input  logic       n_ri,
    input  logic       n_dcd,
    input  logic       loop_en,
    input  logic       ctl_rts,
    input  logic       ctl_dtr,
    input  logic       ctl_out1,
    input  logic       ctl_out2,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int unsigned SETTLE_CYC = SYNC_STAGES + 1;

    line_t pin_n_s;
    line_t loop_v;
    line_t level;
    line_t cur, delta;

    mstat_sync #(
        .WIDTH   (NLINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({n_dcd, n_ri, n_dsr, n_cts}),
        .sync_out (pin_n_s)
    );

    always_comb begin
        loop_v = {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};
        level  = loop_en ? loop_v : ~pin_n_s;
    end

    mstat_delta #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_delta (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_stb (rd_stb),
        .level  (level),
        .cur    (cur),
        .delta  (delta),
        .irq    (irq)
    );

    assign rd_data = {cur, delta};

    // R2: in loopback the status nibble tracks the control outputs
    a_r2_loop_route: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (rd_data[7:4] == $past({ctl_out2, ctl_out1, ctl_dtr, ctl_rts})));

    // R8: the interrupt request agrees with the flag nibble
    a_r8_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[3:0] != 4'h0));
    a_r8_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3:0] != 4'h0) |-> irq);
endmodule

// File: tb/tb_mstat_reg.sv
`timescale 1ns/1ps
module tb_mstat_reg;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_stb = 1'b0;
    logic n_cts = 1'b1, n_dsr = 1'b1, n_ri = 1'b1, n_dcd = 1'b1;
    logic loop_en = 1'b0;
    logic ctl_rts = 1'b0, ctl_dtr = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
    logic [7:0] rd_data;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [3:0] m_cur = 4'h0;
    logic [3:0] m_delta = 4'h0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    mstat_reg dut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb),
        .n_cts(n_cts), .n_dsr(n_dsr), .n_ri(n_ri), .n_dcd(n_dcd),
        .loop_en(loop_en), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr),
        .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] eff();
        if (loop_en) return {ctl_out2, ctl_out1, ctl_dtr, ctl_rts};
        return ~{n_dcd, n_ri, n_dsr, n_cts};
    endfunction

    function automatic logic [3:0] flags(input logic [3:0] o, input logic [3:0] n);
        logic [3:0] f;
        f = o ^ n;
        f[2] = o[2] & ~n[2];
        return f;
    endfunction

    // monitor: compares every read against the scoreboard
    always begin
        @(negedge clk);
        #1;
        if (rd_stb) begin
            if (exp_q.size() == 0) begin
                check("R7 unexpected read", rd_data, 8'hxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic do_read(input string req);
        @(negedge clk);
        rd_stb = 1'b1;
        exp_q.push_back({m_cur, m_delta});
        tag_q.push_back(req);
        m_delta = 4'h0;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    // apply new pins/control/loop, update model, let it settle
    task automatic apply(input logic [3:0] pins_n, input logic [3:0] ctl, input logic lp);
        logic [3:0] o, n;
        @(negedge clk);
        o = eff();
        {n_dcd, n_ri, n_dsr, n_cts} = pins_n;
        {ctl_out2, ctl_out1, ctl_dtr, ctl_rts} = ctl;
        loop_en = lp;
        n = eff();
        m_delta = m_delta | flags(o, n);
        m_cur = n;
        repeat (4) @(negedge clk);
        check("R8 irq", {7'd0, irq}, {7'd0, m_delta != 4'h0});
    endtask

    initial begin
        // R9: hold clear-to-send asserted through reset
        n_cts = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        m_cur = 4'b0001;
        check("R9 irq after reset", {7'd0, irq}, 8'h00);
        do_read("R9 reset state");

        // R3: clear-to-send both directions
        apply(4'b1111, 4'h0, 1'b0);
        do_read("R3 cts deassert");
        apply(4'b1110, 4'h0, 1'b0);
        do_read("R3 cts assert R1");
        // R4, R6
        apply(4'b1100, 4'h0, 1'b0);
        apply(4'b0100, 4'h0, 1'b0);
        do_read("R4 R6 dsr dcd");
        apply(4'b1110, 4'h0, 1'b0);
        do_read("R4 R6 back");
        // R5: ring asserted (n_ri 1->0) no flag, then released sets it
        apply(4'b1010, 4'h0, 1'b0);
        do_read("R5 ring lead no flag");
        apply(4'b1110, 4'h0, 1'b0);
        do_read("R5 ring trail flag");
        do_read("R7 cleared by read");

        // R10: latency of a pin change
        @(negedge clk);
        n_dcd = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 not after two edges", rd_data, {m_cur, m_delta});
        @(negedge clk);
        m_cur[3] = 1'b1;
        m_delta[3] = 1'b1;
        check("R10 after three edges", rd_data, {m_cur, m_delta});
        do_read("R1 R6 dcd asserted");

        // R2: loopback routing
        apply(4'b1110, 4'b0000, 1'b1);
        do_read("R2 enter loop");
        apply(4'b1110, 4'b0101, 1'b1);
        do_read("R2 R11 loop route");
        // R11: pins ignored in loopback
        apply(4'b0000, 4'b0101, 1'b1);
        do_read("R11 pins ignored");
        apply(4'b1111, 4'b0101, 1'b1);
        do_read("R11 pins ignored again");

        // R7: change in the read cycle survives
        @(negedge clk);
        rd_stb = 1'b1;
        exp_q.push_back({m_cur, m_delta});
        tag_q.push_back("R7 read in change cycle");
        ctl_rts = 1'b0;
        m_delta = 4'b0001;
        m_cur = 4'b0100;
        @(negedge clk);
        rd_stb = 1'b0;
        check("R7 change kept", rd_data, {m_cur, m_delta});
        check("R8 irq kept", {7'd0, irq}, 8'h01);
        do_read("R7 read after keep");

        // R5 in loopback: out1 falling sets ring flag
        apply(4'b1111, 4'b0000, 1'b1);
        do_read("R5 R11 loop ring");
        apply(4'b1111, 4'b0000, 1'b0);
        do_read("R1 leave loop");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        if (exp_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL R7 pending reads actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule